// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It drives the memory's clock-enable, termination-enable, command strobes, bank address and address bus through the mandatory start-up sequence, and then signals that normal traffic may begin. It stays idle until a power-good input is seen high. It then keeps the clock enable low for a programmed number of cycles, raises it, waits again, and issues a fixed list of eleven commands. That list is: precharge-all, the writes to extended registers 2 and 3, DLL enable, DLL reset, a second precharge-all, two auto-refreshes, the operating mode write, and the off-chip-driver default/exit pair.

Every wait is a cycle count on a configuration input, so the same block serves any clock rate. The register payloads also come from configuration inputs. The sequencer forces only the bits whose values the start-up procedure fixes: the DLL enable and reset bits, the driver calibration field, the uppermost address bit and the all-banks bit. Normal reads and writes, supply monitoring and the driver calibration itself are handled elsewhere.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, clock enable and termination enable are low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111) and done is low. Nothing changes until pwr_stable_i is sampled high in the idle state. pwr_stable_i is ignored once the sequence has started, so dropping it later has no effect.
- R2: Clock enable rises exactly cfg_t_pwr_i cycles after the clock edge that first samples pwr_stable_i high. Only NOP is driven before that, and clock enable never falls again until reset.
- R3: The first command is precharge-all (4'b0010), with address bit 10 high, every other address bit low and bank 0. It is issued cfg_t_cke_i cycles after clock enable rises.
- R4: The eleven commands come in this order: precharge-all, MRS to bank 2, MRS to bank 3, MRS to bank 1 (DLL enable), MRS to bank 0 (DLL reset), precharge-all, refresh (4'b0001), refresh, MRS to bank 0, MRS to bank 1 (calibration default), MRS to bank 1 (calibration exit). Here MRS is 4'b0000. Each command lasts one cycle.
- R5: The bank 2 and bank 3 writes carry cfg_emr2_i and cfg_emr3_i unchanged on the address bus.
- R6: The DLL-enable write carries cfg_emr1_i with address bits 0, 7, 8, 9 and 13 forced low.
- R7: The DLL-reset write carries cfg_mr_i with bit 8 forced high and bit 13 forced low. The later mode write carries cfg_mr_i with bits 8 and 13 both forced low.
- R8: Each command follows the previous one after exactly the programmed gap: cfg_t_mrd_i after a register write, cfg_t_rp_i after a precharge and cfg_t_rfc_i after a refresh. A programmed count of 0 acts as 1.
- R9: The calibration-default write is issued at the later of two times: tMRD after the previous write, or cfg_t_dll_i cycles after the DLL-enable write. It carries the DLL-enable payload with bits 9:7 = 3'b111. The calibration-exit write carries the same payload with bits 9:7 = 3'b000.
- R10: Done rises exactly cfg_t_mrd_i cycles after the calibration-exit write and stays high until reset. Only NOP follows it.
- R11: Termination enable is low in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_stable_i | input | 1 | Supplies and clock are stable; starts the sequence |
| cfg_t_pwr_i | input | CNT_W | Cycles with clock enable low after power is good |
| cfg_t_cke_i | input | CNT_W | Cycles from clock enable high to the first precharge |
| cfg_t_mrd_i | input | CNT_W | Gap after a register write |
| cfg_t_rp_i | input | CNT_W | Gap after a precharge |
| cfg_t_rfc_i | input | CNT_W | Gap after a refresh |
| cfg_t_dll_i | input | CNT_W | Minimum cycles from DLL enable to calibration default |
| cfg_mr_i | input | ADDR_W | Mode register payload |
| cfg_emr1_i | input | ADDR_W | Extended register 1 payload |
| cfg_emr2_i | input | ADDR_W | Extended register 2 payload |
| cfg_emr3_i | input | ADDR_W | Extended register 3 payload |
| ddr_cke_o | output | 1 | Memory clock enable |
| ddr_odt_o | output | 1 | Memory termination enable |
| ddr_cs_n_o | output | 1 | Chip select, active low |
| ddr_ras_n_o | output | 1 | Row strobe, active low |
| ddr_cas_n_o | output | 1 | Column strobe, active low |
| ddr_we_n_o | output | 1 | Write enable, active low |
| ddr_ba_o | output | 2 | Bank address |
| ddr_addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |

## Verification
The bench targets three groups of corner cases. The first is the calibration-default write when the DLL window is longer than the chain of writes before it: a design that ignores the window issues that write too early. The second is counts of 0 and 1: an off-by-one in the gap reload shifts every command by a cycle, and a zero count wraps into a very long stall. The third is payload masking, checked with random payloads that have the forced bits set the wrong way. A design that passes a payload through unmasked drives a wrong DLL, calibration or bit-13 value. A drop of power-good in mid-sequence checks that the sequencer does not restart or stall.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {GAP_MRD, GAP_RP, GAP_RFC} gap_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PWR, ST_SEQ, ST_DONE} state_e;

  localparam int NUM_STEPS = 11;
endpackage

// File: rtl/ddr2_init_wait_cnt.sv
module ddr2_init_wait_cnt #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr1_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  output cmd_e              cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output gap_e              gap_o,
  output logic              dll_mark_o,  // step starts the DLL window
  output logic              dll_gate_o   // step waits for the DLL window
);
  // Force bits lo..hi to val; bits beyond the bus width are skipped.
  function automatic logic [ADDR_W-1:0] force_bits(input logic [ADDR_W-1:0] v,
                                                   input int lo, input int hi,
                                                   input logic val);
    for (int i = 0; i < ADDR_W; i++)
      if (i >= lo && i <= hi) v[i] = val;
    return v;
  endfunction

  logic [ADDR_W-1:0] emr1_base, mr_base;

  always_comb begin
    emr1_base = force_bits(force_bits(force_bits(emr1_i, 0, 0, 1'b0), 7, 9, 1'b0), 13, 13, 1'b0);
    mr_base   = force_bits(mr_i, 13, 13, 1'b0);
    cmd_o      = CMD_NOP;
    ba_o       = 2'd0;
    addr_o     = '0;
    gap_o      = GAP_MRD;
    dll_mark_o = 1'b0;
    dll_gate_o = 1'b0;
    case (int'(step_i))
      0, 5: begin
        cmd_o  = CMD_PRE;
        addr_o = force_bits('0, 10, 10, 1'b1);
        gap_o  = GAP_RP;
      end
      1: begin cmd_o = CMD_MRS; ba_o = 2'd2; addr_o = emr2_i; end
      2: begin cmd_o = CMD_MRS; ba_o = 2'd3; addr_o = emr3_i; end
      3: begin cmd_o = CMD_MRS; ba_o = 2'd1; addr_o = emr1_base; dll_mark_o = 1'b1; end
      4: begin cmd_o = CMD_MRS; ba_o = 2'd0; addr_o = force_bits(mr_base, 8, 8, 1'b1); end
      6, 7: begin cmd_o = CMD_REF; gap_o = GAP_RFC; end
      8: begin cmd_o = CMD_MRS; ba_o = 2'd0; addr_o = force_bits(mr_base, 8, 8, 1'b0); end
      9: begin
        cmd_o      = CMD_MRS;
        ba_o       = 2'd1;
        addr_o     = force_bits(emr1_base, 7, 9, 1'b1);
        dll_gate_o = 1'b1;
      end
      10: begin cmd_o = CMD_MRS; ba_o = 2'd1; addr_o = emr1_base; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,   // at least 11
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_stable_i,
  input  logic [CNT_W-1:0]  cfg_t_pwr_i,
  input  logic [CNT_W-1:0]  cfg_t_cke_i,
  input  logic [CNT_W-1:0]  cfg_t_mrd_i,
  input  logic [CNT_W-1:0]  cfg_t_rp_i,
  input  logic [CNT_W-1:0]  cfg_t_rfc_i,
  input  logic [CNT_W-1:0]  cfg_t_dll_i,
  input  logic [ADDR_W-1:0] cfg_mr_i,
  input  logic [ADDR_W-1:0] cfg_emr1_i,
  input  logic [ADDR_W-1:0] cfg_emr2_i,
  input  logic [ADDR_W-1:0] cfg_emr3_i,
  output logic              ddr_cke_o,
  output logic              ddr_odt_o,
  output logic              ddr_cs_n_o,
  output logic              ddr_ras_n_o,
  output logic              ddr_cas_n_o,
  output logic              ddr_we_n_o,
  output logic [1:0]        ddr_ba_o,
  output logic [ADDR_W-1:0] ddr_addr_o,
  output logic              init_done_o
);
  localparam int STEP_W = $clog2(NUM_STEPS + 1);

  function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  state_e              state_q;
  logic [STEP_W-1:0]   step_q;
  logic                cke_q, odt_q, done_q;
  cmd_e                cmd_q;
  logic [1:0]          ba_q;
  logic [ADDR_W-1:0]   addr_q;

  cmd_e                rom_cmd;
  logic [1:0]          rom_ba;
  logic [ADDR_W-1:0]   rom_addr;
  gap_e                rom_gap;
  logic                rom_mark, rom_gate;

  logic                main_load, main_zero, dll_load, dll_zero;
  logic [CNT_W-1:0]    main_val, gap_cnt;
  logic                issue, finish;

  ddr2_init_step_rom #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) rom_i (
    .step_i(step_q), .mr_i(cfg_mr_i), .emr1_i(cfg_emr1_i), .emr2_i(cfg_emr2_i),
    .emr3_i(cfg_emr3_i), .cmd_o(rom_cmd), .ba_o(rom_ba), .addr_o(rom_addr),
    .gap_o(rom_gap), .dll_mark_o(rom_mark), .dll_gate_o(rom_gate)
  );

  ddr2_init_wait_cnt #(.CNT_W(CNT_W)) main_cnt_i (
    .clk(clk), .rst(rst), .load_i(main_load), .load_val_i(main_val), .zero_o(main_zero)
  );

  ddr2_init_wait_cnt #(.CNT_W(CNT_W)) dll_cnt_i (
    .clk(clk), .rst(rst), .load_i(dll_load), .load_val_i(reload(cfg_t_dll_i)),
    .zero_o(dll_zero)
  );

  always_comb begin
    issue  = (state_q == ST_SEQ) && (int'(step_q) < NUM_STEPS) && main_zero
             && (!rom_gate || dll_zero);
    finish = (state_q == ST_SEQ) && (int'(step_q) == NUM_STEPS) && main_zero;
    case (rom_gap)
      GAP_RP:  gap_cnt = cfg_t_rp_i;
      GAP_RFC: gap_cnt = cfg_t_rfc_i;
      default: gap_cnt = cfg_t_mrd_i;
    endcase
    main_load = 1'b0;
    main_val  = '0;
    if (state_q == ST_IDLE && pwr_stable_i) begin
      main_load = 1'b1;
      main_val  = reload(cfg_t_pwr_i);
    end else if (state_q == ST_PWR && main_zero) begin
      main_load = 1'b1;
      main_val  = reload(cfg_t_cke_i);
    end else if (issue) begin
      main_load = 1'b1;
      main_val  = reload(gap_cnt);
    end
    dll_load = issue && rom_mark;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cke_q   <= 1'b0;
      odt_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      odt_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      case (state_q)
        ST_IDLE: if (pwr_stable_i) state_q <= ST_PWR;
        ST_PWR: if (main_zero) begin
          cke_q   <= 1'b1;
          state_q <= ST_SEQ;
        end
        ST_SEQ: begin
          if (issue) begin
            cmd_q  <= rom_cmd;
            ba_q   <= rom_ba;
            addr_q <= rom_addr;
            step_q <= step_q + 1'b1;
          end
          if (finish) begin
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign ddr_cke_o   = cke_q;
  assign ddr_odt_o   = odt_q;
  assign ddr_cs_n_o  = cmd_q[3];
  assign ddr_ras_n_o = cmd_q[2];
  assign ddr_cas_n_o = cmd_q[1];
  assign ddr_we_n_o  = cmd_q[0];
  assign ddr_ba_o    = ba_q;
  assign ddr_addr_o  = addr_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              ddr_cke_o,
  input logic              ddr_cs_n_o,
  input logic              ddr_ras_n_o,
  input logic              ddr_cas_n_o,
  input logic              ddr_we_n_o,
  input logic [1:0]        ddr_ba_o,
  input logic [ADDR_W-1:0] ddr_addr_o,
  input logic              init_done_o
);
  logic [3:0] cmd;
  assign cmd = {ddr_cs_n_o, ddr_ras_n_o, ddr_cas_n_o, ddr_we_n_o};

  assert_nop_while_cke_low_R2: assert property (@(posedge clk) disable iff (rst)
    !ddr_cke_o |-> cmd == 4'b0111);

  assert_cke_holds_R2: assert property (@(posedge clk) disable iff (rst)
    $past(ddr_cke_o) |-> ddr_cke_o);

  assert_prea_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |-> ddr_addr_o[10]);

  assert_emr1_dll_on_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000 && ddr_ba_o == 2'd1) |-> !ddr_addr_o[0]);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(init_done_o) |-> init_done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> (cmd == 4'b0111 && ddr_cke_o));
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .ddr_cke_o(ddr_cke_o), .ddr_cs_n_o(ddr_cs_n_o),
  .ddr_ras_n_o(ddr_ras_n_o), .ddr_cas_n_o(ddr_cas_n_o), .ddr_we_n_o(ddr_we_n_o),
  .ddr_ba_o(ddr_ba_o), .ddr_addr_o(ddr_addr_o), .init_done_o(init_done_o)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;
  localparam int AW = 14;
  localparam int CW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr = 1'b0;
  logic [CW-1:0] t_pwr, t_cke, t_mrd, t_rp, t_rfc, t_dll;
  logic [AW-1:0] mr, emr1, emr2, emr3;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  ddr2_init_seq #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .pwr_stable_i(pwr),
    .cfg_t_pwr_i(t_pwr), .cfg_t_cke_i(t_cke), .cfg_t_mrd_i(t_mrd),
    .cfg_t_rp_i(t_rp), .cfg_t_rfc_i(t_rfc), .cfg_t_dll_i(t_dll),
    .cfg_mr_i(mr), .cfg_emr1_i(emr1), .cfg_emr2_i(emr2), .cfg_emr3_i(emr3),
    .ddr_cke_o(cke), .ddr_odt_o(odt), .ddr_cs_n_o(cs_n), .ddr_ras_n_o(ras_n),
    .ddr_cas_n_o(cas_n), .ddr_we_n_o(we_n), .ddr_ba_o(ba), .ddr_addr_o(addr),
    .init_done_o(done)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // command recorder, sampled on the falling edge
  int          rec_t [16];
  logic [3:0]  rec_c [16];
  logic [1:0]  rec_b [16];
  logic [AW-1:0] rec_a [16];
  int  n_rec, cke_t, done_t;
  bit  cke_seen, cke_drop, odt_seen, done_seen, done_drop;

  always @(negedge clk) begin
    if (!rst) begin
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (n_rec < 16) begin
          rec_t[n_rec] = cyc; rec_c[n_rec] = {cs_n, ras_n, cas_n, we_n};
          rec_b[n_rec] = ba;  rec_a[n_rec] = addr;
        end
        n_rec++;
      end
      if (cke && !cke_seen) begin cke_seen = 1; cke_t = cyc; end
      if (cke_seen && !cke) cke_drop = 1;
      if (odt) odt_seen = 1;
      if (done && !done_seen) begin done_seen = 1; done_t = cyc; end
      if (done_seen && !done) done_drop = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic logic [AW-1:0] clr(input logic [AW-1:0] v, input int b);
    v[b] = 1'b0; return v;
  endfunction

  // expected command, bank and address for each step
  function automatic logic [3:0] exp_cmd(input int s);
    if (s == 0 || s == 5) return 4'b0010;
    if (s == 6 || s == 7) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] exp_ba(input int s);
    case (s)
      1: return 2'd2;
      2: return 2'd3;
      3, 9, 10: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int s);
    logic [AW-1:0] e1;
    e1 = emr1;
    e1[0] = 0; e1[7] = 0; e1[8] = 0; e1[9] = 0; e1[13] = 0;
    case (s)
      0, 5: return 14'h0400;
      1: return emr2;
      2: return emr3;
      3, 10: return e1;
      4: return clr(mr, 13) | 14'h0100;
      8: return clr(clr(mr, 13), 8);
      9: return e1 | 14'h0380;
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input int s);
    case (s)
      0: return "R3";
      1, 2: return "R5";
      3: return "R6";
      4, 8: return "R7";
      9, 10: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic run_case(input int tp, input int tc, input int tm, input int tr,
                          input int tf, input int td, input int idle, input bit drop);
    int k0, limit;
    int et [11];
    @(negedge clk);
    rst = 1; pwr = 0;
    t_pwr = CW'(tp); t_cke = CW'(tc); t_mrd = CW'(tm);
    t_rp = CW'(tr); t_rfc = CW'(tf); t_dll = CW'(td);
    mr = AW'($urandom); emr1 = AW'($urandom); emr2 = AW'($urandom); emr3 = AW'($urandom);
    repeat (3) @(negedge clk);
    n_rec = 0; cke_seen = 0; cke_drop = 0; odt_seen = 0; done_seen = 0; done_drop = 0;
    rst = 0;
    repeat (idle + 1) @(negedge clk);
    // R1: reset state holds while power-good is low
    chk(!cke && !odt && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && !done && n_rec == 0,
        "R1", "idle outputs", {cke, odt, cs_n, ras_n, cas_n, we_n, done}, 7'b0001110);
    pwr = 1;
    k0 = cyc + 1;
    // expected schedule
    et[0] = k0 + eff(tp) + eff(tc);
    for (int s = 1; s < 11; s++) begin
      int g;
      g = (s - 1 == 0 || s - 1 == 5) ? eff(tr) : (s - 1 == 6 || s - 1 == 7) ? eff(tf) : eff(tm);
      et[s] = et[s-1] + g;
      if (s == 9 && et[3] + eff(td) > et[s]) et[s] = et[3] + eff(td);
    end
    if (drop) begin
      repeat (2) @(negedge clk);
      pwr = 0;  // R1: ignored after start
    end
    limit = et[10] + eff(tm) + 20;
    while (cyc < limit) @(negedge clk);
    chk(cke_seen && cke_t == k0 + eff(tp), "R2", "cke rise cycle", cke_t, k0 + eff(tp));
    chk(!cke_drop, "R2", "cke stays high", cke_drop, 0);
    chk(!odt_seen, "R11", "odt stays low", odt_seen, 0);
    chk(n_rec == 11, "R4", "command count", n_rec, 11);
    for (int s = 0; s < 11 && s < n_rec; s++) begin
      chk(rec_c[s] == exp_cmd(s), "R4", $sformatf("step %0d cmd", s), rec_c[s], exp_cmd(s));
      chk(rec_b[s] == exp_ba(s), tag(s), $sformatf("step %0d bank", s), rec_b[s], exp_ba(s));
      chk(rec_a[s] == exp_addr(s), tag(s), $sformatf("step %0d addr", s), rec_a[s], exp_addr(s));
      chk(rec_t[s] == et[s], (s == 9) ? "R9" : (s == 0) ? "R3" : "R8",
          $sformatf("step %0d cycle", s), rec_t[s], et[s]);
    end
    chk(done_seen && done_t == et[10] + eff(tm), "R10", "done cycle", done_t, et[10] + eff(tm));
    chk(!done_drop, "R10", "done sticky", done_drop, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    // directed: minimum gaps
    run_case(1, 1, 1, 1, 1, 1, 0, 0);
    // directed: zero counts act as one (R8)
    run_case(0, 0, 0, 0, 0, 0, 2, 0);
    // directed: long DLL window dominates, power-good dropped mid-way (R9, R1)
    run_case(3, 2, 2, 3, 4, 300, 5, 1);
    // directed: realistic counts
    run_case(10000, 20, 2, 5, 26, 200, 1, 0);
    // random
    for (int n = 0; n < 10; n++)
      run_case($urandom_range(1, 40), $urandom_range(0, 30), $urandom_range(0, 6),
               $urandom_range(0, 12), $urandom_range(0, 60), $urandom_range(0, 250),
               $urandom_range(0, 8), 1'($urandom_range(0, 1)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule